// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects single-cycle hardware event pulses into a 32-bit pending cause register and gates them with a per-bit mask. It drives one interrupt request line to a host processor. Software reaches the bank over a plain memory-mapped register bus that carries a valid strobe, a write flag, a byte address and write data. Read data comes back from a register one cycle later.

A control register chooses, for each bit, how its pending cause is retired. A bit can be cleared by writing a one to it, or it can clear itself as soon as software reads it. Either the raw cause view or the masked cause view can retire a bit. Software can also raise causes by itself. It can set or clear chosen mask bits without a read-modify-write, through two write-only aliases that sit beside the full mask register. Bit i stands for the same interrupt in every register of the bank.

The bank is a single clocked register set. It has no sequencing state of its own: every access completes in the cycle it is presented.

Top module: `icr_bank`

## Requirements
- R1: The registers sit at these byte offsets: 0x00 clear-mode control, 0x04 cause, 0x08 masked cause, 0x0C cause set, 0x10 mask, 0x14 mask set, 0x18 mask clear. Bit i stands for the same interrupt in all of them. A read presented with bus_valid=1 and bus_write=0 at a clock edge shows its value on bus_rdata after that edge. bus_rdata keeps that value until the next read.
- R2: After reset the control register and the cause register are 0, the mask is all ones, irq is 0 and bus_rdata is 0.
- R3: An evt_in bit that is high at a clock edge sets its cause bit. A write to cause set (0x0C) sets the cause bits where the write data is 1 and leaves the other bits alone.
- R4: The masked cause register (0x08) reads as cause AND NOT mask, so a mask bit of 1 hides that cause.
- R5: When a control bit is 0, that bit is write-one-to-clear. A write of 1 to that bit at 0x04 or at 0x08 clears the cause bit, and a read leaves it unchanged.
- R6: When a control bit is 1, that bit is clear-on-read. A read of 0x04 clears every such bit it returns. A read of 0x08 clears only the unmasked bits it returns. Writes to 0x04 or 0x08 have no effect on such bits.
- R7: When a set (from evt_in or from a cause-set write) and a clear (by a write or by a read) hit the same cause bit in the same cycle, the bit ends up set.
- R8: The mask register (0x10) is read/write. A 1 written to mask set (0x14) sets that mask bit, and a 1 written to mask clear (0x18) clears it. Zero bits in either write leave the mask unchanged.
- R9: Reads of 0x0C, 0x14 and 0x18 return 0. So does a read of an unused or misaligned address.
- R10: irq is a register that holds the OR of cause AND NOT mask as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| evt_in | input | W | Hardware event pulses, one per cause bit |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result of this bank is due exactly one clock edge after the cause that produces it. A read, write or event pulse presented before edge k changes the cause, the mask or bus_rdata at edge k. A change of cause or mask shows on irq at edge k+1. The bench drives its inputs on falling edges and advances a behavioural reference model on each rising edge. It compares bus_rdata and irq with that model on every falling edge. Each directed read is checked against a hand-computed constant one falling edge after it was presented, and each irq check waits one further cycle after the change that causes it.

// File: rtl/icr_pkg.sv
package icr_pkg;

    typedef enum logic [2:0] {
        REG_CTL    = 3'd0,
        REG_CAUSE  = 3'd1,
        REG_MCAUSE = 3'd2,
        REG_CSET   = 3'd3,
        REG_MVAL   = 3'd4,
        REG_MSET   = 3'd5,
        REG_MCLR   = 3'd6,
        REG_NONE   = 3'd7
    } icr_reg_e;

    localparam int REG_USED = 7;

endpackage

// File: rtl/icr_decode.sv
module icr_decode
    import icr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [REG_USED-1:0] wr_sel,
    output logic              rd_en,
    output icr_reg_e          rd_idx
);

    logic     hit;
    logic     upper_ok;
    icr_reg_e idx;

    generate
        if (ADDR_W > 5) begin : g_upper
            assign upper_ok = (bus_addr[ADDR_W-1:5] == '0);
        end else begin : g_exact
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign idx    = icr_reg_e'(bus_addr[4:2]);
    assign hit    = upper_ok && (bus_addr[1:0] == 2'b00);
    assign rd_en  = bus_valid && !bus_write;
    assign rd_idx = hit ? idx : REG_NONE;

    generate
        for (genvar i = 0; i < REG_USED; i++) begin : g_wsel
            assign wr_sel[i] = bus_valid && bus_write && hit && (idx == icr_reg_e'(i));
        end
    endgenerate

endmodule

// File: rtl/icr_cause.sv
module icr_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    input  logic         cset_wr,
    input  logic         cause_wr,
    input  logic         mcause_wr,
    input  logic         cause_rd,
    input  logic         mcause_rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] clr_on_read,
    input  logic [W-1:0] mask,
    output logic [W-1:0] cause_q
);

    logic [W-1:0] set_vec;
    logic [W-1:0] w1c_vec;
    logic [W-1:0] cor_vec;
    logic [W-1:0] cause_d;

    always_comb begin
        set_vec = evt_in | (cset_wr ? wdata : '0);
        w1c_vec = ((cause_wr || mcause_wr) ? wdata : '0) & ~clr_on_read;
        cor_vec = clr_on_read &
                  ((cause_rd  ? cause_q           : '0) |
                   (mcause_rd ? (cause_q & ~mask) : '0));
        // a set in the same cycle overrides any clear
        cause_d = (cause_q & ~(w1c_vec | cor_vec)) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

endmodule

// File: rtl/icr_mask.sv
module icr_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mval_wr,
    input  logic         mset_wr,
    input  logic         mclr_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mval_wr) mask_q <= wdata;
        else if (mset_wr) mask_q <= mask_q | wdata;
        else if (mclr_wr) mask_q <= mask_q & ~wdata;
    end

endmodule

// File: rtl/icr_bank.sv
module icr_bank
    import icr_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      evt_in,
    output logic              irq
);

    logic [REG_USED-1:0] wr_sel;
    logic                rd_en;
    icr_reg_e            rd_idx;
    logic [W-1:0]        ctl_q;
    logic [W-1:0]        cause_q;
    logic [W-1:0]        mask_q;
    logic [W-1:0]        rd_mux;
    logic [W-1:0]        rdata_q;
    logic                irq_q;

    icr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_sel    (wr_sel),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx)
    );

    icr_cause #(.W(W)) u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_in      (evt_in),
        .cset_wr     (wr_sel[REG_CSET]),
        .cause_wr    (wr_sel[REG_CAUSE]),
        .mcause_wr   (wr_sel[REG_MCAUSE]),
        .cause_rd    (rd_en && (rd_idx == REG_CAUSE)),
        .mcause_rd   (rd_en && (rd_idx == REG_MCAUSE)),
        .wdata       (bus_wdata),
        .clr_on_read (ctl_q),
        .mask        (mask_q),
        .cause_q     (cause_q)
    );

    icr_mask #(.W(W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .mval_wr (wr_sel[REG_MVAL]),
        .mset_wr (wr_sel[REG_MSET]),
        .mclr_wr (wr_sel[REG_MCLR]),
        .wdata   (bus_wdata),
        .mask_q  (mask_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                 ctl_q <= '0;
        else if (wr_sel[REG_CTL])   ctl_q <= bus_wdata;
    end

    always_comb begin
        unique case (rd_idx)
            REG_CTL:    rd_mux = ctl_q;
            REG_CAUSE:  rd_mux = cause_q;
            REG_MCAUSE: rd_mux = cause_q & ~mask_q;
            REG_MVAL:   rd_mux = mask_q;
            REG_CSET,
            REG_MSET,
            REG_MCLR,
            REG_NONE:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (rd_en) rdata_q <= rd_mux;
            irq_q <= |(cause_q & ~mask_q);
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;

endmodule

// File: rtl/icr_bank_chk.sv
module icr_bank_chk #(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      evt_in,
    input logic              irq,
    input logic [W-1:0]      cause_q,
    input logic [W-1:0]      mask_q
);

    logic is_rd;
    logic is_wr;
    logic aligned;
    assign is_rd   = bus_valid && !bus_write;
    assign is_wr   = bus_valid && bus_write;
    assign aligned = (bus_addr >> 5) == '0 && bus_addr[1:0] == 2'b00;

    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(cause_q & ~mask_q)));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((cause_q & $past(evt_in)) == $past(evt_in)));

    assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && (bus_addr[4:2] == 3'd3 || bus_addr[4:2] == 3'd5 ||
                   bus_addr[4:2] == 3'd6)) |=> (bus_rdata == '0));

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && aligned && bus_addr[4:2] == 3'd5) |=>
        ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_masked_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && aligned && bus_addr[4:2] == 3'd2) |=>
        (bus_rdata == $past(cause_q & ~mask_q)));

endmodule

bind icr_bank icr_bank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .irq       (irq),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/icr_bank_test.sv
module icr_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int ADDR_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic [W-1:0]      evt_in = '0;
    logic              irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctl = '0, m_cause = '0, m_mask = '1, m_rd = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icr_bank #(.W(W), .ADDR_W(ADDR_W)) uut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .evt_in (evt_in), .irq (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int     a;
        logic   rd, wr;
        logic [31:0] nc;
        if (!rst_n) begin
            m_ctl = '0; m_cause = '0; m_mask = '1; m_rd = '0; m_irq = 1'b0;
        end else begin
            a  = (bus_addr[1:0] == 2'b00) ? int'(bus_addr) : -1;
            rd = bus_valid && !bus_write;
            wr = bus_valid && bus_write;
            m_irq = (m_cause & ~m_mask) != 0;
            if (rd) begin
                case (a)
                    'h00: m_rd = m_ctl;
                    'h04: m_rd = m_cause;
                    'h08: m_rd = m_cause & ~m_mask;
                    'h10: m_rd = m_mask;
                    default: m_rd = '0;
                endcase
            end
            for (int b = 0; b < 32; b++) begin
                logic s, c;
                s = evt_in[b] || (wr && a == 'h0C && bus_wdata[b]);
                if (m_ctl[b])
                    c = m_cause[b] && rd && (a == 'h04 || (a == 'h08 && !m_mask[b]));
                else
                    c = wr && (a == 'h04 || a == 'h08) && bus_wdata[b];
                nc[b] = s ? 1'b1 : (c ? 1'b0 : m_cause[b]);
            end
            m_cause = nc;
            if (wr && a == 'h10) m_mask = bus_wdata;
            if (wr && a == 'h14) m_mask = m_mask | bus_wdata;
            if (wr && a == 'h18) m_mask = m_mask & ~bus_wdata;
            if (wr && a == 'h00) m_ctl = bus_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1 rdata vs model", bus_rdata, m_rd);
            check("R10 irq vs model", {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        check("R2 irq after reset", {31'd0, irq}, 32'd0);
        check("R2 rdata after reset", bus_rdata, 32'd0);
        rd_reg(5'h00, 32'h0, "R2 control reset");
        rd_reg(5'h04, 32'h0, "R2 cause reset");
        rd_reg(5'h10, 32'hFFFF_FFFF, "R2 mask reset");

        rd_reg(5'h0C, 32'h0, "R9 cause set reads 0");
        rd_reg(5'h14, 32'h0, "R9 mask set reads 0");
        rd_reg(5'h18, 32'h0, "R9 mask clear reads 0");
        rd_reg(5'h1C, 32'h0, "R9 unused reads 0");
        rd_reg(5'h11, 32'h0, "R9 misaligned reads 0");

        pulse(32'h0000_0005);
        rd_reg(5'h04, 32'h0000_0005, "R3 event sets cause");
        wr_reg(5'h0C, 32'h0000_0030);
        rd_reg(5'h04, 32'h0000_0035, "R3 cause set write");
        rd_reg(5'h08, 32'h0, "R4 all masked");
        check_irq(1'b0, "R10 irq low while masked");

        wr_reg(5'h18, 32'h0000_0011);
        rd_reg(5'h10, 32'hFFFF_FFEE, "R8 mask clear");
        check("R10 irq high once unmasked", {31'd0, irq}, 32'd1);
        rd_reg(5'h08, 32'h0000_0011, "R4 masked view");
        wr_reg(5'h14, 32'h0000_0001);
        rd_reg(5'h10, 32'hFFFF_FFEF, "R8 mask set");
        wr_reg(5'h10, 32'h0000_FF00);
        rd_reg(5'h10, 32'h0000_FF00, "R8 mask write");
        rd_reg(5'h08, 32'h0000_0035, "R4 masked view after write");

        wr_reg(5'h04, 32'h0000_0004);
        rd_reg(5'h04, 32'h0000_0031, "R5 w1c via cause");
        wr_reg(5'h08, 32'h0000_0001);
        rd_reg(5'h04, 32'h0000_0030, "R5 w1c via masked view");
        rd_reg(5'h04, 32'h0000_0030, "R5 read does not clear w1c");

        wr_reg(5'h00, 32'h0000_0030);
        rd_reg(5'h00, 32'h0000_0030, "R1 control readback");
        wr_reg(5'h04, 32'h0000_0030);
        rd_reg(5'h04, 32'h0000_0030, "R6 write ignored, read returns");
        rd_reg(5'h04, 32'h0, "R6 read cleared");
        pulse(32'h0000_00A0);
        wr_reg(5'h14, 32'h0000_0020);
        wr_reg(5'h08, 32'h0000_0020);
        rd_reg(5'h08, 32'h0000_0080, "R6 masked read value");
        rd_reg(5'h04, 32'h0000_00A0, "R6 masked read kept hidden bit");
        rd_reg(5'h04, 32'h0000_0080, "R6 raw read cleared cor bit");
        wr_reg(5'h00, 32'h0000_00B0);
        rd_reg(5'h08, 32'h0000_0080, "R6 masked read of cor bit");
        rd_reg(5'h04, 32'h0, "R6 masked read cleared it");

        @(negedge clk);
        evt_in = 32'h4; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h4;
        @(negedge clk);
        evt_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
        rd_reg(5'h04, 32'h0000_0004, "R7 set beats w1c");
        wr_reg(5'h0C, 32'h0000_0010);
        @(negedge clk);
        evt_in = 32'h10; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'h04;
        @(negedge clk);
        evt_in = '0; bus_valid = 1'b0;
        check("R7 read during event", bus_rdata, 32'h0000_0014);
        rd_reg(5'h04, 32'h0000_0014, "R7 set beats cor");
        rd_reg(5'h04, 32'h0000_0004, "R6 cor after collision");

        check_irq(1'b1, "R10 irq with pending bit");
        wr_reg(5'h10, 32'hFFFF_FFFF);
        check_irq(1'b0, "R10 irq drops one cycle after mask");
        wr_reg(5'h10, 32'h0);
        check_irq(1'b1, "R10 irq returns");
        wr_reg(5'h04, 32'h0000_0004);
        check_irq(1'b0, "R10 irq drops after clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule